// File: doc/BRIEF.md
# Framed Serial PCM Voice Port

This block is the digital serial edge of a narrow-band voice codec. Linear samples 14 bits wide cross it in both directions once per 8 kHz frame. The port runs from a 2.048 MHz master clock, which gives 256 clock periods per frame. An external frame-sync pulse marks where each frame begins. In each frame the port serialises one parallel word from the converter side (the ADC sample) onto the serial output, most significant bit first. In the same frame it deserialises one word from the serial input and hands it to the converter side (the DAC sample), together with a single-cycle valid strobe.

The two directions use opposite clock edges. Frame sync and serial input are sampled on falling edges. The serial output is launched on rising edges, so a receiver that samples on the falling edge sees every output bit half a period after it is launched. Separate enables stand for the power state of the transmit and receive paths. A loopback control replaces the outgoing ADC word with the word that was last received.

Top module: `pcm_voice_port`

## Requirements
- R1: A frame starts at a falling edge where `fs` is sampled high and the previous falling-edge sample of `fs` was low. Holding `fs` high for several clocks starts only one frame. If `fs` is already high when reset is released, no frame starts until it has been seen low.
- R2: At the rising edge that follows the start falling edge, `adc_word` is latched and `adc_take` is high for exactly one clock. `sout` presents bit 13 (MSB) from that rising edge, and the remaining bits follow in descending order on the next 13 rising edges.
- R3: After the 14th bit, `sout` is low until the next frame starts.
- R4: `sin` is sampled on 14 consecutive falling edges, beginning with the falling edge after the start edge. The first sample is bit 13 (MSB) of the received word.
- R5: At the falling edge that captures the 14th bit, `dac_word` takes the received word and `dac_valid` is high for exactly one clock. At all other times `dac_word` holds its value.
- R6: If `loop_en` is high at the latch edge of R2, the word sent is the last word delivered on `dac_word` instead of `adc_word`, and `adc_take` stays low.
- R7: While `tx_en` is low, `sout` is low and `adc_take` is low. A word in progress is abandoned. Raising `tx_en` again mid-frame leaves `sout` low until the next frame.
- R8: While `rx_en` is low, nothing is captured, `dac_valid` stays low, `dac_word` holds, and a partial word is discarded.
- R9: Active-low `rst_n` is asynchronous. It forces `sout`, `adc_take`, `dac_valid` and `dac_word` to zero and clears any frame in progress.
- R10: A new frame start before the current word is complete restarts both directions from the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs | input | 1 | Frame-sync pulse, sampled on falling edges |
| sin | input | 1 | Serial receive data, sampled on falling edges |
| tx_en | input | 1 | Transmit path powered |
| rx_en | input | 1 | Receive path powered |
| loop_en | input | 1 | Send the last received word instead of the ADC word |
| adc_word | input | 14 | Parallel word to transmit |
| adc_take | output | 1 | One-clock strobe when `adc_word` is latched |
| sout | output | 1 | Serial transmit data, launched on rising edges |
| dac_word | output | 14 | Last received word |
| dac_valid | output | 1 | One-clock strobe when `dac_word` is updated |

## Verification
The hardest cases to reach are the ones where a frame is interrupted part way through. These include a fresh sync edge arriving before the 14th bit, a power enable that drops and returns inside one frame, and a reset asserted mid-word. Each of them leaves partial state that has to be discarded correctly. The stimulus builds frames of chosen length and sync width and toggles the enables and reset at specific bit positions within a frame. A behavioural model written with queues tracks what each edge should do, and loopback frames are chained so that the word received in one frame must reappear on the output in the next.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/100ps
package pcm_port_pkg;
  typedef enum logic {
    TX_SRC_ADC  = 1'b0,
    TX_SRC_LOOP = 1'b1
  } tx_src_e;

  localparam int PCM_DEFAULT_W = 14;
endpackage

// File: rtl/pcm_frame_detect.sv
`timescale 1ns/100ps
module pcm_frame_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic fs,
  output logic start_q
);
  logic fs_prev_q;
  logic frame_edge;

  // Rising edge of sync as seen on two consecutive falling-edge samples.
  assign frame_edge = fs & ~fs_prev_q;

  // Previous sample resets high so a sync already high at reset release
  // does not open a frame.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b1;
      start_q   <= 1'b0;
    end else begin
      fs_prev_q <= fs;
      start_q   <= frame_edge;
    end
  end
endmodule

// File: rtl/pcm_rx_deser.sv
`timescale 1ns/100ps
module pcm_rx_deser #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         start_q,
  input  logic         sin,
  output logic [W-1:0] word,
  output logic         valid,
  output logic         rx_done,
  output logic         rx_busy
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] left_q;
  logic [W-1:0]  acc_q;

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] a, input logic b);
    return {a[W-2:0], b};
  endfunction

  // Last bit is being captured at this falling edge.
  assign rx_done = rx_en && !start_q && (left_q == CW'(1));
  assign rx_busy = (left_q != '0);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      acc_q  <= '0;
      word   <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!rx_en) begin
        left_q <= '0;
      end else if (start_q) begin
        acc_q  <= shift_in('0, sin);
        left_q <= CW'(W - 1);
      end else if (rx_busy) begin
        acc_q  <= shift_in(acc_q, sin);
        left_q <= left_q - 1'b1;
        if (rx_done) begin
          word  <= shift_in(acc_q, sin);
          valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tx_ser.sv
`timescale 1ns/100ps
module pcm_tx_ser
  import pcm_port_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic         start_q,
  input  logic         loop_en,
  input  logic [W-1:0] adc_word,
  input  logic [W-1:0] loop_word,
  output logic         sout,
  output logic         adc_take,
  output logic         tx_load,
  output logic         tx_busy
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] left_q;
  logic [W-1:0]  sh_q;
  tx_src_e       src;
  logic [W-1:0]  first_word;

  function automatic logic [W-1:0] pick_word(input tx_src_e s,
                                             input logic [W-1:0] a,
                                             input logic [W-1:0] l);
    return (s == TX_SRC_LOOP) ? l : a;
  endfunction

  assign src        = loop_en ? TX_SRC_LOOP : TX_SRC_ADC;
  assign first_word = pick_word(src, adc_word, loop_word);
  assign tx_load    = tx_en && start_q;
  assign tx_busy    = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      sh_q     <= '0;
      sout     <= 1'b0;
      adc_take <= 1'b0;
    end else begin
      adc_take <= 1'b0;
      if (!tx_en) begin
        left_q <= '0;
        sout   <= 1'b0;
      end else if (tx_load) begin
        sout     <= first_word[W-1];
        sh_q     <= {first_word[W-2:0], 1'b0};
        left_q   <= CW'(W - 1);
        adc_take <= (src == TX_SRC_ADC);
      end else if (tx_busy) begin
        sout   <= sh_q[W-1];
        sh_q   <= {sh_q[W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end else begin
        sout <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_voice_port.sv
`timescale 1ns/100ps
module pcm_voice_port #(
  parameter int SAMPLE_W = 14
) (
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                fs,
  input  logic                sin,
  input  logic                tx_en,
  input  logic                rx_en,
  input  logic                loop_en,
  input  logic [SAMPLE_W-1:0] adc_word,
  output logic                adc_take,
  output logic                sout,
  output logic [SAMPLE_W-1:0] dac_word,
  output logic                dac_valid
);
  // Named internal events, observed by the bound checker.
  logic start_q;
  logic rx_done;
  logic rx_busy;
  logic tx_load;
  logic tx_busy;

  pcm_frame_detect u_frame (
    .clk     (mclk),
    .rst_n   (rst_n),
    .fs      (fs),
    .start_q (start_q)
  );

  pcm_rx_deser #(.W(SAMPLE_W)) u_rx (
    .clk     (mclk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .start_q (start_q),
    .sin     (sin),
    .word    (dac_word),
    .valid   (dac_valid),
    .rx_done (rx_done),
    .rx_busy (rx_busy)
  );

  pcm_tx_ser #(.W(SAMPLE_W)) u_tx (
    .clk       (mclk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .start_q   (start_q),
    .loop_en   (loop_en),
    .adc_word  (adc_word),
    .loop_word (dac_word),
    .sout      (sout),
    .adc_take  (adc_take),
    .tx_load   (tx_load),
    .tx_busy   (tx_busy)
  );
endmodule

// File: rtl/pcm_voice_port_chk.sv
`timescale 1ns/100ps
module pcm_voice_port_chk #(
  parameter int W = 14
) (
  input logic         mclk,
  input logic         rst_n,
  input logic         tx_en,
  input logic         rx_en,
  input logic         loop_en,
  input logic         sout,
  input logic         adc_take,
  input logic [W-1:0] dac_word,
  input logic         dac_valid,
  input logic         start_q,
  input logic         rx_done,
  input logic         rx_busy,
  input logic         tx_load,
  input logic         tx_busy
);
  p_start_single_r1: assert property (@(negedge mclk) disable iff (!rst_n)
    start_q |=> !start_q);

  p_take_single_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    adc_take |=> !adc_take);

  p_take_after_start_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    adc_take |-> $past(start_q));

  p_sout_low_idle_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    (!tx_busy && !start_q) |=> !sout);

  p_valid_follows_done_r5: assert property (@(negedge mclk) disable iff (!rst_n)
    rx_done |=> (dac_valid && !rx_busy));

  p_valid_single_r5: assert property (@(negedge mclk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);

  p_word_hold_r5: assert property (@(negedge mclk) disable iff (!rst_n)
    !dac_valid |-> $stable(dac_word));

  p_loop_no_take_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    (tx_load && loop_en) |=> !adc_take);

  p_tx_off_quiet_r7: assert property (@(posedge mclk) disable iff (!rst_n)
    !tx_en |=> (!sout && !adc_take));

  p_valid_needs_rx_r8: assert property (@(negedge mclk) disable iff (!rst_n)
    dac_valid |-> $past(rx_en));
endmodule

bind pcm_voice_port pcm_voice_port_chk #(.W(SAMPLE_W)) u_chk (
  .mclk      (mclk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .loop_en   (loop_en),
  .sout      (sout),
  .adc_take  (adc_take),
  .dac_word  (dac_word),
  .dac_valid (dac_valid),
  .start_q   (start_q),
  .rx_done   (rx_done),
  .rx_busy   (rx_busy),
  .tx_load   (tx_load),
  .tx_busy   (tx_busy)
);

// File: tb/test_pcm_voice_port.sv
`timescale 1ns/100ps
module test_pcm_voice_port;
  localparam int W = 14;

  logic         mclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fs = 1'b0, sin = 1'b0;
  logic         tx_en = 1'b1, rx_en = 1'b1, loop_en = 1'b0;
  logic [W-1:0] adc_word = '0;
  logic         adc_take, sout, dac_valid;
  logic [W-1:0] dac_word;

  int    n_tests = 0, n_fail = 0;
  string tag = "R9";
  bit    done = 0;

  always #2.5 mclk = ~mclk;

  pcm_voice_port #(.SAMPLE_W(W)) i_pcm_voice_port (
    .mclk(mclk), .rst_n(rst_n), .fs(fs), .sin(sin), .tx_en(tx_en),
    .rx_en(rx_en), .loop_en(loop_en), .adc_word(adc_word),
    .adc_take(adc_take), .sout(sout), .dac_word(dac_word),
    .dac_valid(dac_valid)
  );

  // Behavioural reference state
  bit           m_prev_fs = 1, m_start = 0, m_valid = 0, m_sout = 0, m_take = 0;
  int           m_rx_left = 0, m_acc = 0;
  logic [W-1:0] m_dac = '0;
  bit           m_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [W-1:0] w;
    if (!rst_n) begin
      m_prev_fs = 1; m_start = 0; m_valid = 0; m_sout = 0; m_take = 0;
      m_rx_left = 0; m_acc = 0; m_dac = '0; m_q.delete();
      return;
    end
    // falling edge
    m_valid = 0;
    if (!rx_en) m_rx_left = 0;
    else if (m_start) begin m_acc = int'(sin); m_rx_left = W - 1; end
    else if (m_rx_left > 0) begin
      m_acc = (m_acc * 2) + int'(sin);
      m_rx_left--;
      if (m_rx_left == 0) begin m_dac = m_acc[W-1:0]; m_valid = 1; end
    end
    m_start = fs && !m_prev_fs;
    m_prev_fs = fs;
    // rising edge
    m_take = 0;
    if (!tx_en) begin m_q.delete(); m_sout = 0; end
    else if (m_start) begin
      w = loop_en ? m_dac : adc_word;
      m_take = !loop_en;
      m_q.delete();
      for (int i = W - 1; i >= 0; i--) m_q.push_back(w[i]);
      m_sout = m_q.pop_front();
    end else if (m_q.size() > 0) m_sout = m_q.pop_front();
    else m_sout = 0;
  endtask

  task automatic tick(input logic f, input logic s);
    fs = f; sin = s;
    model_step();
    @(posedge mclk); #1.25;
    check(sout == m_sout, tag, "sout", int'(sout), int'(m_sout));
    check(adc_take == m_take, tag, "adc_take", int'(adc_take), int'(m_take));
    check(dac_valid == m_valid, tag, "dac_valid", int'(dac_valid), int'(m_valid));
    check(dac_word == m_dac, tag, "dac_word", int'(dac_word), int'(m_dac));
  endtask

  // One frame: sync high for hi clocks, rx word on sin MSB first, sout bits collected.
  task automatic frame(input int len, input int hi, input logic [W-1:0] rxw,
                       output logic [W-1:0] got);
    got = '0;
    for (int c = 0; c < len; c++) begin
      tick(c < hi, (c >= 1 && c <= W) ? rxw[W-c] : 1'b0);
      if (c < W) got[W-1-c] = sout;
    end
  endtask

  initial begin
    logic [W-1:0] g;
    // R9: reset state with sync activity
    for (int i = 0; i < 4; i++) tick(i[0], 1'b1);
    check(sout == 0 && adc_take == 0 && dac_valid == 0 && dac_word == 0,
          "R9", "reset outputs", int'({sout, adc_take, dac_valid}), 0);
    // R1: sync already high at release opens no frame
    tag = "R1";
    fs = 1; rst_n = 1;
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b1);
    check(dac_valid == 0 && sout == 0, "R1", "no frame while sync held", int'(sout), 0);
    tick(1'b0, 1'b0);
    // R2 R4 R5: normal frames with varied patterns
    tag = "R2";
    adc_word = 14'h2AAA; frame(40, 1, 14'h1555, g);
    check(g == 14'h2AAA, "R2", "sent word", int'(g), 'h2AAA);
    check(dac_word == 14'h1555, "R4", "received word", int'(dac_word), 'h1555);
    tag = "R4";
    adc_word = 14'h3FFF; frame(40, 1, 14'h2001, g);
    check(g == 14'h3FFF, "R2", "sent word", int'(g), 'h3FFF);
    check(dac_word == 14'h2001, "R5", "received word", int'(dac_word), 'h2001);
    // R1: wide sync starts once
    tag = "R1";
    adc_word = 14'h0001; frame(40, 6, 14'h3C0F, g);
    check(g == 14'h0001, "R1", "wide sync word", int'(g), 1);
    // R3: long frame, output low after word
    tag = "R3";
    adc_word = 14'h3FFF; frame(256, 1, 14'h0FF0, g);
    check(sout == 0, "R3", "sout after word", int'(sout), 0);
    // R6: loopback returns previous received word
    tag = "R6";
    loop_en = 1; adc_word = 14'h1234; frame(40, 1, 14'h2B6D, g);
    check(g == 14'h0FF0, "R6", "loop word", int'(g), 'h0FF0);
    frame(40, 1, 14'h0003, g);
    check(g == 14'h2B6D, "R6", "loop chain", int'(g), 'h2B6D);
    loop_en = 0;
    // R7: tx off mid-frame, back on mid-frame
    tag = "R7";
    adc_word = 14'h3FFF;
    for (int c = 0; c < 40; c++) begin
      if (c == 6) tx_en = 0;
      if (c == 9) tx_en = 1;
      tick(c == 0, 1'b0);
      if (c >= 6 && c < 14)
        check(sout == 0, "R7", "sout while/after off", int'(sout), 0);
    end
    // R8: rx off mid-frame, word held
    tag = "R8";
    for (int c = 0; c < 40; c++) begin
      if (c == 5) rx_en = 0;
      if (c == 8) rx_en = 1;
      tick(c == 0, 1'b1);
    end
    check(dac_word == 14'h0000, "R8", "word held", int'(dac_word), 0);
    // R10: early restart
    tag = "R10";
    adc_word = 14'h2222; frame(8, 1, 14'h3333, g);
    adc_word = 14'h0ABC; frame(40, 1, 14'h1DEF, g);
    check(g == 14'h0ABC, "R10", "restart word", int'(g), 'h0ABC);
    check(dac_word == 14'h1DEF, "R10", "restart rx word", int'(dac_word), 'h1DEF);
    // R9: reset mid-frame
    tag = "R9";
    for (int c = 0; c < 40; c++) begin
      if (c == 5) rst_n = 0;
      if (c == 7) rst_n = 1;
      tick(c == 0, 1'b1);
      if (c == 5)
        check(sout == 0 && dac_word == 0, "R9", "mid-frame reset", int'(dac_word), 0);
    end
    tag = "R2";
    adc_word = 14'h1F0F; frame(40, 1, 14'h2468, g);
    check(g == 14'h1F0F, "R2", "after reset word", int'(g), 'h1F0F);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule